// File: doc/BRIEF.md
# Coherent Snooping Cache Line Controller

This block keeps a small direct-mapped cache coherent with its peers on a shared bus. Every line holds an address tag, one block of data and a two-bit coherence state: Invalid, Shared, Exclusive (clean, sole copy) or Modified (dirty, sole copy). Processor reads and writes are served locally whenever the state allows it. Otherwise the controller issues one of four bus transactions: a shared fetch, an exclusive fetch, an ownership upgrade or a write-back.

A snoop port watches the transactions of other agents. When a snooped read hits a valid line, the controller asserts a shared indication. When it hits a dirty line, it also supplies the line (intervention) so that memory can capture it. A snooped intent-to-write removes the local copy. Coherence is kept per block, so two words of one block are never tracked apart.

The shared bus never carries a grant to this cache in the same cycle as a snooped transaction from another agent.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid: the first access to any address issues a bus fetch, and a snoop to any block reports neither shared nor intervention. The processor port is ready, and no bus request or response is pending.
- R2: A read miss answered with shared-in low installs the line as Exclusive. A later write to it completes with no bus transaction, and reads then return the written word without bus traffic.
- R3: A read miss answered with shared-in high installs the line as Shared, so a later write to it must use the bus.
- R4: A write miss issues an exclusive fetch (command code 1), merges the written word into the fetched block and installs it as Modified.
- R5: A write to a Shared line issues an upgrade (command code 2) and becomes Modified when the grant arrives.
- R6: A snooped intent-to-write that hits a valid line invalidates it without asserting shared, and the next local access to it misses.
- R7: A snooped read that hits a Modified line asserts intervention and shared in the same cycle and drives the whole current block, and the line becomes Shared.
- R8: A snooped read that hits an Exclusive line asserts shared with no intervention, and the line becomes Shared.
- R9: A miss whose victim is Modified first issues a write-back (command code 3) carrying the victim's block address and data, then the fetch. Each request is held stable until it is granted, and a shared fetch uses command code 0.
- R10: A snoop and a processor request in the same cycle: the snoop is taken first, the processor port is not ready in that cycle, and the processor request then sees the state as the snoop left it.
- R11: A snooped intent-to-write naming a block invalidates every word of it, including words the local processor wrote.
- R12: A snoop whose tag differs from the resident line, or whose line is Invalid, produces no shared or intervention output and leaves local data and state as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write word |
| cpu_req_ready | output | 1 | Request accepted at this edge when valid |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | DATA_W | Read word, or the written word for a write |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | 0 shared fetch, 1 exclusive fetch, 2 upgrade, 3 write-back |
| bus_req_blk | output | ADDR_W-log2(WORDS) | Block address |
| bus_req_line | output | DATA_W*WORDS | Write-back data |
| bus_gnt | input | 1 | Transaction completes at this edge |
| bus_fill_line | input | DATA_W*WORDS | Fetched block, valid with the grant |
| bus_shared_in | input | 1 | Another cache holds the block, valid with a fetch grant |
| snp_valid | input | 1 | Another agent's transaction is being snooped |
| snp_excl | input | 1 | 1 = intent-to-write, 0 = read |
| snp_blk | input | ADDR_W-log2(WORDS) | Snooped block address |
| snp_shared_out | output | 1 | This cache holds the snooped block (read only) |
| snp_intervene | output | 1 | This cache supplies the dirty block |
| snp_line | output | DATA_W*WORDS | Intervention data, zero otherwise |

## Verification
A snooped transaction and a processor request can arrive in the same cycle on the same block, and the order in which they are taken decides whether the processor's write hits silently or goes to the bus. The bench holds a dirty line, then drives a processor write and a snooped intent-to-write to that block on the same cycle. It judges the outcome from the processor port being not ready in that cycle, from the intervention carrying the old block, and from the write then issuing an exclusive fetch. Had the write been taken first, it would have completed with no bus traffic.

// File: rtl/mesi_pkg.sv
`timescale 1ns/1ps
package mesi_pkg;
   typedef enum logic [1:0] {
      ST_I = 2'd0,
      ST_S = 2'd1,
      ST_E = 2'd2,
      ST_M = 2'd3
   } line_st_e;

   typedef enum logic [1:0] {
      BUS_RD_SH = 2'd0,
      BUS_RD_EX = 2'd1,
      BUS_UPGR  = 2'd2,
      BUS_WBACK = 2'd3
   } bus_cmd_e;

   typedef enum logic [1:0] {
      PF_IDLE  = 2'd0,
      PF_WBACK = 2'd1,
      PF_FILL  = 2'd2,
      PF_UPGR  = 2'd3
   } pfsm_e;
endpackage

// File: rtl/mesi_tag_store.sv
`timescale 1ns/1ps
module mesi_tag_store
   import mesi_pkg::*;
#(
   parameter int LINES = 4,
   parameter int TAG_W = 9
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   pw_en,
   input  logic [$clog2(LINES)-1:0] pw_idx,
   input  logic                   pw_tag_en,
   input  logic [TAG_W-1:0]       pw_tag,
   input  line_st_e               pw_state,
   input  logic                   sw_en,
   input  logic [$clog2(LINES)-1:0] sw_idx,
   input  line_st_e               sw_state,
   output logic [LINES*TAG_W-1:0] tags_flat,
   output logic [2*LINES-1:0]     st_flat
);
   localparam int IDX_W = $clog2(LINES);

   for (genvar g = 0; g < LINES; g++) begin : g_line
      line_st_e         st_q;
      logic [TAG_W-1:0] tag_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q  <= ST_I;
            tag_q <= '0;
         end else begin
            if (pw_en && pw_idx == IDX_W'(g)) begin
               st_q <= pw_state;
               if (pw_tag_en) tag_q <= pw_tag;
            end
            // snoop port wins on a collision
            if (sw_en && sw_idx == IDX_W'(g)) st_q <= sw_state;
         end
      end

      assign tags_flat[g*TAG_W +: TAG_W] = tag_q;
      assign st_flat[g*2 +: 2]           = st_q;
   end
endmodule

// File: rtl/mesi_data_store.sv
`timescale 1ns/1ps
module mesi_data_store #(
   parameter int LINES  = 4,
   parameter int LINE_W = 32
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(LINES)-1:0] widx,
   input  logic [LINE_W-1:0]        wline,
   input  logic [$clog2(LINES)-1:0] ridx_a,
   output logic [LINE_W-1:0]        rline_a,
   input  logic [$clog2(LINES)-1:0] ridx_b,
   output logic [LINE_W-1:0]        rline_b
);
   logic [LINE_W-1:0] mem_q [LINES];

   always_ff @(posedge clk) begin
      if (we) mem_q[widx] <= wline;
   end

   assign rline_a = mem_q[ridx_a];
   assign rline_b = mem_q[ridx_b];
endmodule

// File: rtl/mesi_snoop_resp.sv
`timescale 1ns/1ps
module mesi_snoop_resp
   import mesi_pkg::*;
#(
   parameter int TAG_W = 9
) (
   input  logic             snp_valid,
   input  logic             snp_excl,
   input  logic [TAG_W-1:0] snp_tag,
   input  logic [TAG_W-1:0] line_tag,
   input  line_st_e         line_st,
   output logic             hit,
   output logic             shared_out,
   output logic             intervene,
   output logic             upd_en,
   output line_st_e         upd_state
);
   always_comb begin
      hit        = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);
      shared_out = hit && !snp_excl;
      intervene  = hit && (line_st == ST_M);
      upd_en     = hit;
      upd_state  = snp_excl ? ST_I : ST_S;
   end
endmodule

// File: rtl/mesi_line_ctrl.sv
`timescale 1ns/1ps
module mesi_line_ctrl
   import mesi_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 16,
   parameter int LINES  = 4,
   parameter int WORDS  = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               cpu_req_valid,
   input  logic                               cpu_req_write,
   input  logic [ADDR_W-1:0]                  cpu_req_addr,
   input  logic [DATA_W-1:0]                  cpu_req_wdata,
   output logic                               cpu_req_ready,
   output logic                               cpu_resp_valid,
   output logic [DATA_W-1:0]                  cpu_resp_rdata,
   output logic                               bus_req_valid,
   output logic [1:0]                         bus_req_cmd,
   output logic [ADDR_W-$clog2(WORDS)-1:0]    bus_req_blk,
   output logic [DATA_W*WORDS-1:0]            bus_req_line,
   input  logic                               bus_gnt,
   input  logic [DATA_W*WORDS-1:0]            bus_fill_line,
   input  logic                               bus_shared_in,
   input  logic                               snp_valid,
   input  logic                               snp_excl,
   input  logic [ADDR_W-$clog2(WORDS)-1:0]    snp_blk,
   output logic                               snp_shared_out,
   output logic                               snp_intervene,
   output logic [DATA_W*WORDS-1:0]            snp_line
);
   localparam int IDX_W  = $clog2(LINES);
   localparam int OFF_W  = $clog2(WORDS);
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
   localparam int BLK_W  = ADDR_W - OFF_W;
   localparam int LINE_W = DATA_W * WORDS;

   if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (WORDS < 2 || (1 << OFF_W) != WORDS) begin : g_bad_words
      $error("WORDS must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W too small for LINES and WORDS");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   // ---------------- request latch and fields ----------------
   pfsm_e              fsm_q, fsm_d;
   logic [ADDR_W-1:0]  rq_addr_q;
   logic               rq_wr_q;
   logic [DATA_W-1:0]  rq_wdata_q;

   logic [IDX_W-1:0]   in_idx, rq_idx, look_idx, s_idx;
   logic [TAG_W-1:0]   in_tag, rq_tag, s_tag;
   logic [OFF_W-1:0]   in_off, rq_off;
   logic [BLK_W-1:0]   rq_blk;

   assign in_idx = cpu_req_addr[OFF_W +: IDX_W];
   assign in_tag = cpu_req_addr[ADDR_W-1 -: TAG_W];
   assign in_off = cpu_req_addr[OFF_W-1:0];
   assign rq_idx = rq_addr_q[OFF_W +: IDX_W];
   assign rq_tag = rq_addr_q[ADDR_W-1 -: TAG_W];
   assign rq_off = rq_addr_q[OFF_W-1:0];
   assign rq_blk = rq_addr_q[ADDR_W-1:OFF_W];
   assign s_idx  = snp_blk[IDX_W-1:0];
   assign s_tag  = snp_blk[BLK_W-1 -: TAG_W];

   assign look_idx = (fsm_q == PF_IDLE) ? in_idx : rq_idx;

   // ---------------- storage ----------------
   logic [LINES*TAG_W-1:0] tags_flat;
   logic [2*LINES-1:0]     st_flat;
   logic                   pw_en, pw_tag_en;
   line_st_e               pw_state;
   logic                   sw_en;
   line_st_e               sw_state;
   logic                   dw_en;
   logic [LINE_W-1:0]      dw_line;
   logic [LINE_W-1:0]      cur_line, s_line_data;

   mesi_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .pw_en     (pw_en),
      .pw_idx    (look_idx),
      .pw_tag_en (pw_tag_en),
      .pw_tag    (rq_tag),
      .pw_state  (pw_state),
      .sw_en     (sw_en),
      .sw_idx    (s_idx),
      .sw_state  (sw_state),
      .tags_flat (tags_flat),
      .st_flat   (st_flat)
   );

   mesi_data_store #(.LINES(LINES), .LINE_W(LINE_W)) u_data (
      .clk     (clk),
      .we      (dw_en),
      .widx    (look_idx),
      .wline   (dw_line),
      .ridx_a  (look_idx),
      .rline_a (cur_line),
      .ridx_b  (s_idx),
      .rline_b (s_line_data)
   );

   logic [TAG_W-1:0] cur_tag, s_line_tag;
   line_st_e         cur_st, s_line_st;

   assign cur_tag    = tags_flat[look_idx*TAG_W +: TAG_W];
   assign cur_st     = line_st_e'(st_flat[look_idx*2 +: 2]);
   assign s_line_tag = tags_flat[s_idx*TAG_W +: TAG_W];
   assign s_line_st  = line_st_e'(st_flat[s_idx*2 +: 2]);

   // ---------------- snoop response ----------------
   logic s_hit;

   mesi_snoop_resp #(.TAG_W(TAG_W)) u_snoop (
      .snp_valid  (snp_valid),
      .snp_excl   (snp_excl),
      .snp_tag    (s_tag),
      .line_tag   (s_line_tag),
      .line_st    (s_line_st),
      .hit        (s_hit),
      .shared_out (snp_shared_out),
      .intervene  (snp_intervene),
      .upd_en     (sw_en),
      .upd_state  (sw_state)
   );

   assign snp_line = (s_hit && snp_intervene) ? s_line_data : '0;

   // ---------------- word merge ----------------
   logic [LINE_W-1:0] mrg_base, merged;
   logic [OFF_W-1:0]  mrg_off;
   logic [DATA_W-1:0] mrg_data;

   assign mrg_base = (fsm_q == PF_FILL) ? bus_fill_line : cur_line;
   assign mrg_off  = (fsm_q == PF_IDLE) ? in_off : rq_off;
   assign mrg_data = (fsm_q == PF_IDLE) ? cpu_req_wdata : rq_wdata_q;

   for (genvar w = 0; w < WORDS; w++) begin : g_merge
      assign merged[w*DATA_W +: DATA_W] =
         (mrg_off == OFF_W'(w)) ? mrg_data : mrg_base[w*DATA_W +: DATA_W];
   end

   // ---------------- control ----------------
   logic              take, resp_set, in_hit, up_ok;
   logic [DATA_W-1:0] resp_word;

   assign cpu_req_ready = (fsm_q == PF_IDLE) && !snp_valid;
   assign in_hit        = (cur_st != ST_I) && (cur_tag == in_tag);
   assign up_ok         = (cur_st == ST_S) && (cur_tag == rq_tag);

   always_comb begin
      fsm_d         = fsm_q;
      take          = 1'b0;
      pw_en         = 1'b0;
      pw_tag_en     = 1'b0;
      pw_state      = ST_I;
      dw_en         = 1'b0;
      dw_line       = merged;
      resp_set      = 1'b0;
      resp_word     = '0;
      bus_req_valid = 1'b0;
      bus_req_cmd   = BUS_RD_SH;
      bus_req_blk   = rq_blk;
      bus_req_line  = '0;
      unique case (fsm_q)
         PF_IDLE: begin
            if (cpu_req_valid && cpu_req_ready) begin
               take = 1'b1;
               if (in_hit) begin
                  if (!cpu_req_write) begin
                     resp_set  = 1'b1;
                     resp_word = cur_line[in_off*DATA_W +: DATA_W];
                  end else if (cur_st == ST_S) begin
                     fsm_d = PF_UPGR;
                  end else begin
                     pw_en     = 1'b1;
                     pw_state  = ST_M;
                     dw_en     = 1'b1;
                     resp_set  = 1'b1;
                     resp_word = cpu_req_wdata;
                  end
               end else if (cur_st == ST_M) begin
                  fsm_d = PF_WBACK;
               end else begin
                  fsm_d = PF_FILL;
               end
            end
         end
         PF_WBACK: begin
            if (cur_st == ST_M) begin
               bus_req_valid = 1'b1;
               bus_req_cmd   = BUS_WBACK;
               bus_req_blk   = {cur_tag, rq_idx};
               bus_req_line  = cur_line;
               if (bus_gnt) begin
                  pw_en    = 1'b1;
                  pw_state = ST_I;
                  fsm_d    = PF_FILL;
               end
            end else begin
               // victim already surrendered to a snoop
               fsm_d = PF_FILL;
            end
         end
         PF_FILL: begin
            bus_req_valid = 1'b1;
            bus_req_cmd   = rq_wr_q ? BUS_RD_EX : BUS_RD_SH;
            if (bus_gnt) begin
               pw_en     = 1'b1;
               pw_tag_en = 1'b1;
               pw_state  = rq_wr_q ? ST_M : (bus_shared_in ? ST_S : ST_E);
               dw_en     = 1'b1;
               dw_line   = rq_wr_q ? merged : bus_fill_line;
               resp_set  = 1'b1;
               resp_word = rq_wr_q ? rq_wdata_q : bus_fill_line[rq_off*DATA_W +: DATA_W];
               fsm_d     = PF_IDLE;
            end
         end
         PF_UPGR: begin
            if (up_ok) begin
               bus_req_valid = 1'b1;
               bus_req_cmd   = BUS_UPGR;
               if (bus_gnt) begin
                  pw_en     = 1'b1;
                  pw_state  = ST_M;
                  dw_en     = 1'b1;
                  resp_set  = 1'b1;
                  resp_word = rq_wdata_q;
                  fsm_d     = PF_IDLE;
               end
            end else begin
               // copy lost to a snooped intent-to-write: fetch it exclusively
               fsm_d = PF_FILL;
            end
         end
         default: fsm_d = PF_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsm_q          <= PF_IDLE;
         rq_addr_q      <= '0;
         rq_wr_q        <= 1'b0;
         rq_wdata_q     <= '0;
         cpu_resp_valid <= 1'b0;
         cpu_resp_rdata <= '0;
      end else begin
         fsm_q          <= fsm_d;
         cpu_resp_valid <= resp_set;
         if (resp_set) cpu_resp_rdata <= resp_word;
         if (take) begin
            rq_addr_q  <= cpu_req_addr;
            rq_wr_q    <= cpu_req_write;
            rq_wdata_q <= cpu_req_wdata;
         end
      end
   end
endmodule

// File: rtl/mesi_line_chk.sv
`timescale 1ns/1ps
module mesi_line_chk #(
   parameter int LINES = 4,
   parameter int IDX_W = 2,
   parameter int BLK_W = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpu_req_ready,
   input logic             bus_req_valid,
   input logic [1:0]       bus_req_cmd,
   input logic [BLK_W-1:0] bus_req_blk,
   input logic             bus_gnt,
   input logic             snp_valid,
   input logic             snp_excl,
   input logic [BLK_W-1:0] snp_blk,
   input logic             snp_shared_out,
   input logic             snp_intervene,
   input logic [2*LINES-1:0] st_flat
);
   logic [IDX_W-1:0] sidx_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sidx_q <= '0;
      else        sidx_q <= snp_blk[IDX_W-1:0];
   end

   assert_snoop_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |-> !cpu_req_ready);

   assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid && !bus_gnt && !snp_valid |=>
         bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_blk));

   assert_excl_no_shared_R6: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid && snp_excl |-> !snp_shared_out);

   assert_interv_in_snoop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      snp_intervene |-> snp_valid);

   assert_interv_shared_R7: assert property (@(posedge clk) disable iff (!rst_n)
      snp_intervene && !snp_excl |-> snp_shared_out);

   assert_excl_invalidates_R11: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid && snp_excl && snp_intervene |=> st_flat[sidx_q*2 +: 2] == 2'd0);

   assert_read_leaves_shared_R8: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid && snp_shared_out |=> st_flat[sidx_q*2 +: 2] == 2'd1);
endmodule

bind mesi_line_ctrl mesi_line_chk #(.LINES(LINES), .IDX_W(IDX_W), .BLK_W(BLK_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cpu_req_ready  (cpu_req_ready),
   .bus_req_valid  (bus_req_valid),
   .bus_req_cmd    (bus_req_cmd),
   .bus_req_blk    (bus_req_blk),
   .bus_gnt        (bus_gnt),
   .snp_valid      (snp_valid),
   .snp_excl       (snp_excl),
   .snp_blk        (snp_blk),
   .snp_shared_out (snp_shared_out),
   .snp_intervene  (snp_intervene),
   .st_flat        (st_flat)
);

// File: tb/mesi_line_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_line_ctrl_tb_top;
   localparam int AW = 12;
   localparam int DW = 16;
   localparam int BW = 11;
   localparam int LW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
   logic [AW-1:0] cpu_req_addr = '0;
   logic [DW-1:0] cpu_req_wdata = '0;
   logic          cpu_req_ready, cpu_resp_valid;
   logic [DW-1:0] cpu_resp_rdata;
   logic          bus_req_valid;
   logic [1:0]    bus_req_cmd;
   logic [BW-1:0] bus_req_blk;
   logic [LW-1:0] bus_req_line;
   logic          bus_gnt = 1'b0, bus_shared_in = 1'b0;
   logic [LW-1:0] bus_fill_line = '0;
   logic          snp_valid = 1'b0, snp_excl = 1'b0;
   logic [BW-1:0] snp_blk = '0;
   logic          snp_shared_out, snp_intervene;
   logic [LW-1:0] snp_line;

   always #10 clk = ~clk;   // 50 MHz

   mesi_line_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
      .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
      .cpu_req_ready(cpu_req_ready), .cpu_resp_valid(cpu_resp_valid),
      .cpu_resp_rdata(cpu_resp_rdata),
      .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd),
      .bus_req_blk(bus_req_blk), .bus_req_line(bus_req_line),
      .bus_gnt(bus_gnt), .bus_fill_line(bus_fill_line), .bus_shared_in(bus_shared_in),
      .snp_valid(snp_valid), .snp_excl(snp_excl), .snp_blk(snp_blk),
      .snp_shared_out(snp_shared_out), .snp_intervene(snp_intervene), .snp_line(snp_line)
   );

   // reference memory (per block) and expected word values (per address)
   logic [LW-1:0] mem  [2**BW];
   logic [DW-1:0] gold [2**AW];
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   function automatic logic [DW-1:0] init_word(input int a);
      return 16'hA000 ^ DW'(a * 7);
   endfunction

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   task automatic cpu_op(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic sh, output int nb, output logic [1:0] c0,
                         output logic [1:0] c1, output logic [DW-1:0] rd, output bit ok);
      int guard;
      nb = 0; c0 = 0; c1 = 0; rd = 0; ok = 1;
      @(negedge clk);
      cpu_req_valid = 1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = d;
      #2;
      guard = 0;
      while (!cpu_req_ready && guard < 50) begin @(negedge clk); #2; guard++; end
      @(negedge clk);
      cpu_req_valid = 0;
      guard = 0;
      while (!cpu_resp_valid && guard < 50) begin
         if (bus_req_valid) begin
            if (nb == 0) c0 = bus_req_cmd; else c1 = bus_req_cmd;
            nb++;
            if (bus_req_cmd == 2'd3) mem[bus_req_blk] = bus_req_line;
            bus_fill_line = mem[bus_req_blk];
            bus_shared_in = sh;
            bus_gnt = 1;
            @(negedge clk);
            bus_gnt = 0;
         end else begin
            @(negedge clk);
         end
         guard++;
      end
      ok = cpu_resp_valid;
      rd = cpu_resp_rdata;
      if (wr) gold[a] = d;
   endtask

   task automatic snoop_op(input logic ex, input logic [BW-1:0] b,
                           output logic sh, output logic iv, output logic [LW-1:0] ln);
      @(negedge clk);
      snp_valid = 1; snp_excl = ex; snp_blk = b;
      #2;
      sh = snp_shared_out; iv = snp_intervene; ln = snp_line;
      if (iv) mem[b] = ln;   // memory captures the intervened block
      @(negedge clk);
      snp_valid = 0;
   endtask

   typedef struct packed {
      logic [1:0]    op;    // 0 read, 1 write, 2 snoop read, 3 snoop intent-to-write
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      logic          sh;    // shared-in for fetches
      logic [1:0]    nb;    // expected bus transactions
      logic [1:0]    c0;
      logic [1:0]    c1;
      logic          xsh;
      logic          xiv;
      logic [3:0]    rq;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 12'h010, 16'h0000, 1'b0, 2'd1, 2'd0, 2'd0, 1'b0, 1'b0, 4'd2},  // R2 miss -> E
      '{2'd1, 12'h010, 16'h1111, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd2},  // R2 silent E->M
      '{2'd0, 12'h010, 16'h0000, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd2},  // R2 hit
      '{2'd2, 12'h010, 16'h0000, 1'b0, 2'd0, 2'd0, 2'd0, 1'b1, 1'b1, 4'd7},  // R7 M read snoop
      '{2'd1, 12'h011, 16'h2222, 1'b0, 2'd1, 2'd2, 2'd0, 1'b0, 1'b0, 4'd5},  // R5 upgrade
      '{2'd3, 12'h010, 16'h0000, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 4'd11}, // R11 whole block
      '{2'd0, 12'h011, 16'h0000, 1'b1, 2'd1, 2'd0, 2'd0, 1'b0, 1'b0, 4'd3},  // R3 -> S
      '{2'd1, 12'h010, 16'h3333, 1'b0, 2'd1, 2'd2, 2'd0, 1'b0, 1'b0, 4'd3},  // R3 write needs bus
      '{2'd0, 12'h030, 16'h0000, 1'b0, 2'd2, 2'd3, 2'd0, 1'b0, 1'b0, 4'd9},  // R9 write-back first
      '{2'd0, 12'h010, 16'h0000, 1'b0, 2'd1, 2'd0, 2'd0, 1'b0, 1'b0, 4'd9},  // R9 data survived
      '{2'd2, 12'h010, 16'h0000, 1'b0, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 4'd8},  // R8 E read snoop
      '{2'd1, 12'h010, 16'h4444, 1'b0, 2'd1, 2'd2, 2'd0, 1'b0, 1'b0, 4'd8},  // R8 now S
      '{2'd1, 12'h012, 16'h5555, 1'b0, 2'd1, 2'd1, 2'd0, 1'b0, 1'b0, 4'd4},  // R4 write miss
      '{2'd2, 12'h030, 16'h0000, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd12}, // R12 tag mismatch
      '{2'd3, 12'h012, 16'h0000, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 4'd6},  // R6 invalidate
      '{2'd0, 12'h012, 16'h0000, 1'b0, 2'd1, 2'd0, 2'd0, 1'b0, 1'b0, 4'd6},  // R6 next access misses
      '{2'd1, 12'h013, 16'h6666, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd2},  // R2 silent
      '{2'd3, 12'h052, 16'h0000, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd12}, // R12 other tag
      '{2'd0, 12'h013, 16'h0000, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd12}  // R12 line untouched
   };

   initial begin
      for (int b = 0; b < 2**BW; b++) begin
         mem[b] = {init_word(2*b+1), init_word(2*b)};
      end
      for (int a = 0; a < 2**AW; a++) gold[a] = init_word(a);
   end

   initial begin
      int nb; logic [1:0] c0, c1; logic [DW-1:0] rd; bit ok;
      logic sh, iv; logic [LW-1:0] ln;
      string tag;

      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #2;
      // R1 reset state
      check("R1 ready", cpu_req_ready, 1);
      check("R1 bus idle", bus_req_valid, 0);
      check("R1 resp idle", cpu_resp_valid, 0);
      snoop_op(1'b0, 11'h008, sh, iv, ln);
      check("R1 snoop shared", sh, 0);
      check("R1 snoop intervene", iv, 0);

      for (int i = 0; i < NV; i++) begin
         tag = $sformatf("R%0d v%0d", VECS[i].rq, i);
         if (VECS[i].op < 2) begin
            cpu_op(VECS[i].op[0], VECS[i].addr, VECS[i].data, VECS[i].sh, nb, c0, c1, rd, ok);
            check({tag, " completed"}, ok, 1);
            check({tag, " bus count"}, nb, VECS[i].nb);
            if (VECS[i].nb > 0) check({tag, " cmd0"}, c0, VECS[i].c0);
            if (VECS[i].nb > 1) check({tag, " cmd1"}, c1, VECS[i].c1);
            check({tag, " data"}, rd, gold[VECS[i].addr]);
         end else begin
            snoop_op(VECS[i].op[0], VECS[i].addr[AW-1:1], sh, iv, ln);
            check({tag, " shared"}, sh, VECS[i].xsh);
            check({tag, " intervene"}, iv, VECS[i].xiv);
            if (VECS[i].xiv)
               check({tag, " block"}, ln, {gold[{VECS[i].addr[AW-1:1], 1'b1}],
                                            gold[{VECS[i].addr[AW-1:1], 1'b0}]});
         end
      end

      // R10: block 0x008 is Modified; processor write and snooped intent-to-write collide
      @(negedge clk);
      cpu_req_valid = 1; cpu_req_write = 1; cpu_req_addr = 12'h010; cpu_req_wdata = 16'h7777;
      snp_valid = 1; snp_excl = 1; snp_blk = 11'h008;
      #2;
      check("R10 ready low in collision", cpu_req_ready, 0);
      check("R10 snoop intervenes", snp_intervene, 1);
      check("R10 old block", snp_line, {gold[12'h011], gold[12'h010]});
      if (snp_intervene) mem[11'h008] = snp_line;
      @(negedge clk);
      snp_valid = 0;
      cpu_req_valid = 0;
      cpu_op(1'b1, 12'h010, 16'h7777, 1'b0, nb, c0, c1, rd, ok);
      check("R10 write after snoop misses", nb, 1);
      check("R10 exclusive fetch", c0, 1);
      check("R10 response", rd, 16'h7777);
      cpu_op(1'b0, 12'h011, 16'h0, 1'b0, nb, c0, c1, rd, ok);
      check("R4 merged block kept other word", rd, gold[12'h011]);
      check("R4 hit after fill", nb, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule